// File: doc/BRIEF.md
# Eight-Bit Execution Unit with Bus Selector

This block is the combinational datapath core of a small register machine. Two operands, A and B, feed an arithmetic and logic unit and, for A alone, a shifter. The carry into the adder is picked from four sources, so the same adder serves plain add, add with carry, subtract and the single-operand forms. A four-way selector then drives the internal bus from the shifter, the ALU, a program-counter input or a memory-buffer input.

The ALU can emit all-zero and all-one words. A sequencer outside the block places one of these constants in B to form clear, increment, decrement and complement from the ordinary functions. Compare is a B-minus-A function: it sets the flags, and the controller simply does not write the bus back. A carry flag and a negative flag are latched on a strobe. Rotate-left-through-carry and the pass-through shifter setting read the stored carry.

Top module: `exu_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both `carry_q` and `neg_q` become 0.
- R2: `bus_sel` picks the bus source: 0 shifter, 1 ALU, 2 `pc_in`, 3 `mbr_in`. The bus is combinational and needs no clock.
- R3: ALU code 1 gives A+B+cin. Its carry output is the adder carry-out. `cin_sel` picks cin: 0 A bit 7, 1 stored carry flag, 2 constant 0, 3 constant 1.
- R4: ALU code 2 gives A+~B+cin, which with cin=1 is A-B. Its carry output is 1 exactly when no borrow occurs.
- R5: ALU code 3 gives B+~A+cin, which with cin=1 is B-A. Its flags are latched whatever `bus_sel` shows, so a compare leaves the bus free.
- R6: ALU code 0 passes A, and codes 4, 5 and 6 give AND, OR and XOR. These logic codes give a carry output of 0. The unused codes 9 to 15 give 0 with a carry output of 0.
- R7: ALU code 7 gives all zeros and code 8 gives all ones, each with a carry output of 0. With these constants in B, code 1 forms increment and decrement, and code 6 forms complement.
- R8: Shifter code 0 and the unused codes 5 to 7 pass A unchanged and keep the stored carry. Code 1 is an arithmetic right shift that copies bit 7. Code 2 is a logical right shift. Both right shifts send the old bit 0 to carry.
- R9: Shifter code 3 shifts left, putting 0 in bit 0 and old bit 7 in carry. Code 4 rotates left through carry: the stored carry goes to bit 0 and old bit 7 goes to carry.
- R10: On a rising edge with `flag_we` high, `neg_q` takes bit 7 of the source result and `carry_q` takes its carry. The source is the shifter when `bus_sel` is 0 and the ALU otherwise. With `flag_we` low, both flags hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 8 | Operand A |
| b_in | input | 8 | Operand B |
| alu_fn | input | 4 | ALU function code |
| sh_fn | input | 3 | Shifter function code |
| cin_sel | input | 2 | Adder carry-in source |
| bus_sel | input | 2 | Bus source select |
| pc_in | input | 8 | Program-counter value offered to the bus |
| mbr_in | input | 8 | Memory-buffer value offered to the bus |
| flag_we | input | 1 | Flag latch strobe |
| bus_out | output | 8 | Internal bus |
| carry_q | output | 1 | Stored carry flag |
| neg_q | output | 1 | Stored negative flag |

## Verification
The bench builds the unit at its default width of eight bits. At that width the directed values reach every boundary the requirements name: carry-out on 0xFF+0x01, borrow on a smaller minuend, sign change at 0x7F+1, and bit 7 and bit 0 moving into carry in both shift directions. The bench also chains operations through the stored carry. Add-with-carry, rotate and pass-through each see a carry left by an earlier strobe, and the hold check changes every input while the strobe is low.

// File: rtl/exu_pkg.sv
// Package: shared codes for the execution unit.
// Assumes: codes are decoded by a sequencer that drives the unit's select ports.
package exu_pkg;
    typedef enum logic [3:0] {
        ALU_PASSA = 4'd0,
        ALU_ADD   = 4'd1,
        ALU_SUB   = 4'd2,
        ALU_BSUBA = 4'd3,
        ALU_AND   = 4'd4,
        ALU_OR    = 4'd5,
        ALU_XOR   = 4'd6,
        ALU_ZERO  = 4'd7,
        ALU_ONES  = 4'd8
    } alu_fn_e;

    typedef enum logic [2:0] {
        SH_PASS = 3'd0,
        SH_ASR  = 3'd1,
        SH_LSR  = 3'd2,
        SH_LSL  = 3'd3,
        SH_RLC  = 3'd4
    } sh_fn_e;

    typedef enum logic [1:0] {
        CIN_AMSB = 2'd0,
        CIN_FLAG = 2'd1,
        CIN_ZERO = 2'd2,
        CIN_ONE  = 2'd3
    } cin_sel_e;

    typedef enum logic [1:0] {
        BUS_SHIFT = 2'd0,
        BUS_ALU   = 2'd1,
        BUS_PC    = 2'd2,
        BUS_MBR   = 2'd3
    } bus_sel_e;
endpackage

// File: rtl/exu_alu.sv
// Module: exu_alu
// Combinational arithmetic and logic function generator.
// Assumes: cin is already selected by the caller; carry output is the adder
// carry-out for arithmetic codes and 0 for every other code.
module exu_alu
    import exu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   fn,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int SW = W + 1;

    logic [SW-1:0] sum_ab;
    logic [SW-1:0] sum_anb;
    logic [SW-1:0] sum_bna;
    logic [SW-1:0] cin_ext;

    // Purpose: form the three adder variants in parallel.
    always_comb begin
        cin_ext = {{W{1'b0}}, cin};
        sum_ab  = {1'b0, a} + {1'b0, b} + cin_ext;
        sum_anb = {1'b0, a} + {1'b0, ~b} + cin_ext;
        sum_bna = {1'b0, b} + {1'b0, ~a} + cin_ext;
    end

    // Purpose: pick the function result and its carry.
    always_comb begin
        res  = '0;
        cout = 1'b0;
        case (alu_fn_e'(fn))
            ALU_PASSA: res = a;
            ALU_ADD:   {cout, res} = sum_ab;
            ALU_SUB:   {cout, res} = sum_anb;
            ALU_BSUBA: {cout, res} = sum_bna;
            ALU_AND:   res = a & b;
            ALU_OR:    res = a | b;
            ALU_XOR:   res = a ^ b;
            ALU_ZERO:  res = '0;
            ALU_ONES:  res = '1;
            default:   res = '0;
        endcase
    end
endmodule

// File: rtl/exu_shifter.sv
// Module: exu_shifter
// Combinational one-place shifter/rotator on operand A.
// Assumes: cflag is the stored carry; unused codes behave as pass-through.
module exu_shifter
    import exu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [2:0]   fn,
    input  logic         cflag,
    output logic [W-1:0] res,
    output logic         cout
);
    // Purpose: produce the shifted word and the bit moved into carry.
    always_comb begin
        res  = a;
        cout = cflag;
        case (sh_fn_e'(fn))
            SH_ASR: begin res = {a[W-1], a[W-1:1]}; cout = a[0];   end
            SH_LSR: begin res = {1'b0,   a[W-1:1]}; cout = a[0];   end
            SH_LSL: begin res = {a[W-2:0], 1'b0};   cout = a[W-1]; end
            SH_RLC: begin res = {a[W-2:0], cflag};  cout = a[W-1]; end
            default: begin res = a; cout = cflag; end
        endcase
    end
endmodule

// File: rtl/exu_flags.sv
// Module: exu_flags
// Carry and negative flag register with load strobe.
// Assumes: synchronous active-low reset clears both flags.
module exu_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic c_d,
    input  logic n_d,
    output logic c_q,
    output logic n_q
);
    // Purpose: latch flags on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= 1'b0;
            n_q <= 1'b0;
        end else if (we) begin
            c_q <= c_d;
            n_q <= n_d;
        end
    end
endmodule

// File: rtl/exu_core.sv
// Module: exu_core (top)
// Execution unit: carry-in selector, ALU, shifter, bus selector, flags.
// Assumes: all selects are held stable around the flag-latch edge.
module exu_core
    import exu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [3:0]   alu_fn,
    input  logic [2:0]   sh_fn,
    input  logic [1:0]   cin_sel,
    input  logic [1:0]   bus_sel,
    input  logic [W-1:0] pc_in,
    input  logic [W-1:0] mbr_in,
    input  logic         flag_we,
    output logic [W-1:0] bus_out,
    output logic         carry_q,
    output logic         neg_q
);
    localparam int MSB = W - 1;

    logic         cin;
    logic [W-1:0] alu_res;
    logic         alu_c;
    logic [W-1:0] sh_res;
    logic         sh_c;
    logic         flag_c_d;
    logic         flag_n_d;

    // Purpose: choose the adder carry-in.
    always_comb begin
        case (cin_sel_e'(cin_sel))
            CIN_AMSB: cin = a_in[MSB];
            CIN_FLAG: cin = carry_q;
            CIN_ZERO: cin = 1'b0;
            default:  cin = 1'b1;
        endcase
    end

    exu_alu #(.W(W)) u_alu (
        .a    (a_in),
        .b    (b_in),
        .fn   (alu_fn),
        .cin  (cin),
        .res  (alu_res),
        .cout (alu_c)
    );

    exu_shifter #(.W(W)) u_sh (
        .a     (a_in),
        .fn    (sh_fn),
        .cflag (carry_q),
        .res   (sh_res),
        .cout  (sh_c)
    );

    // Purpose: drive the bus from the selected source.
    always_comb begin
        case (bus_sel_e'(bus_sel))
            BUS_SHIFT: bus_out = sh_res;
            BUS_ALU:   bus_out = alu_res;
            BUS_PC:    bus_out = pc_in;
            default:   bus_out = mbr_in;
        endcase
    end

    // Purpose: take flags from the shifter on shifter-bus cycles, else the ALU.
    always_comb begin
        if (bus_sel_e'(bus_sel) == BUS_SHIFT) begin
            flag_c_d = sh_c;
            flag_n_d = sh_res[MSB];
        end else begin
            flag_c_d = alu_c;
            flag_n_d = alu_res[MSB];
        end
    end

    exu_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (flag_we),
        .c_d   (flag_c_d),
        .n_d   (flag_n_d),
        .c_q   (carry_q),
        .n_q   (neg_q)
    );
endmodule

// File: rtl/exu_core_chk.sv
// Module: exu_core_chk
// Port-level properties of exu_core, attached by bind.
// Assumes: same width parameter as the bound instance.
module exu_core_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [3:0]   alu_fn,
    input logic [2:0]   sh_fn,
    input logic [1:0]   cin_sel,
    input logic [1:0]   bus_sel,
    input logic [W-1:0] pc_in,
    input logic [W-1:0] mbr_in,
    input logic         flag_we,
    input logic [W-1:0] bus_out,
    input logic         carry_q,
    input logic         neg_q
);
    logic [W:0] add_ref;
    assign add_ref = {1'b0, a_in} + {1'b0, b_in};

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!carry_q && !neg_q));

    assert_bus_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel == 2'd2 |-> bus_out == pc_in);

    assert_bus_mbr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel == 2'd3 |-> bus_out == mbr_in);

    assert_add_plain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 2'd1 && alu_fn == 4'd1 && cin_sel == 2'd2)
            |-> bus_out == add_ref[W-1:0]);

    assert_const_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 2'd1 && alu_fn == 4'd7) |-> bus_out == '0);

    assert_const_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 2'd1 && alu_fn == 4'd8) |-> bus_out == '1);

    assert_shift_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 2'd0 && sh_fn == 3'd0) |-> bus_out == a_in);

    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable({carry_q, neg_q}));

    assert_neg_from_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && bus_sel <= 2'd1) |=> neg_q == $past(bus_out[W-1]));
endmodule

bind exu_core exu_core_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_in    (a_in),
    .b_in    (b_in),
    .alu_fn  (alu_fn),
    .sh_fn   (sh_fn),
    .cin_sel (cin_sel),
    .bus_sel (bus_sel),
    .pc_in   (pc_in),
    .mbr_in  (mbr_in),
    .flag_we (flag_we),
    .bus_out (bus_out),
    .carry_q (carry_q),
    .neg_q   (neg_q)
);

// File: tb/tb_exu_core.sv
// Directed bench for exu_core: one task per scenario.
module tb_exu_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a_in = '0, b_in = '0, pc_in = '0, mbr_in = '0;
    logic [3:0] alu_fn = '0;
    logic [2:0] sh_fn = '0;
    logic [1:0] cin_sel = '0, bus_sel = '0;
    logic       flag_we = 1'b0;
    logic [7:0] bus_out;
    logic       carry_q, neg_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    exu_core dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .alu_fn(alu_fn), .sh_fn(sh_fn), .cin_sel(cin_sel), .bus_sel(bus_sel),
        .pc_in(pc_in), .mbr_in(mbr_in), .flag_we(flag_we),
        .bus_out(bus_out), .carry_q(carry_q), .neg_q(neg_q)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive inputs after a falling edge, then settle.
    task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic [3:0] fn,
                         input logic [2:0] sh, input logic [1:0] cs, input logic [1:0] bs);
        @(negedge clk);
        a_in = a; b_in = b; alu_fn = fn; sh_fn = sh; cin_sel = cs; bus_sel = bs;
        #2;
    endtask

    // Pulse the flag strobe across one rising edge.
    task automatic latch();
        flag_we = 1'b1;
        @(posedge clk);
        #2;
        flag_we = 1'b0;
    endtask

    task automatic run_op(input string req, input logic [7:0] a, input logic [7:0] b,
                          input logic [3:0] fn, input logic [2:0] sh, input logic [1:0] cs,
                          input logic [1:0] bs, input logic [7:0] ebus, input logic ec);
        drive(a, b, fn, sh, cs, bs);
        chk(req, bus_out, ebus);
        latch();
        chk(req, {7'd0, carry_q}, {7'd0, ec});
        chk(req, {7'd0, neg_q}, {7'd0, ebus[7]});
    endtask

    task automatic t_reset();  // R1
        chk("R1 carry", {7'd0, carry_q}, 8'd0);
        chk("R1 neg", {7'd0, neg_q}, 8'd0);
    endtask

    task automatic t_bus();    // R2
        pc_in = 8'h5A; mbr_in = 8'hC3;
        drive(8'h3C, 8'h0F, 4'd4, 3'd0, 2'd2, 2'd0);
        chk("R2 shifter", bus_out, 8'h3C);
        drive(8'h3C, 8'h0F, 4'd4, 3'd0, 2'd2, 2'd1);
        chk("R2 alu", bus_out, 8'h0C);
        drive(8'h3C, 8'h0F, 4'd4, 3'd0, 2'd2, 2'd2);
        chk("R2 pc", bus_out, 8'h5A);
        drive(8'h3C, 8'h0F, 4'd4, 3'd0, 2'd2, 2'd3);
        chk("R2 mbr", bus_out, 8'hC3);
    endtask

    task automatic t_add();    // R3
        logic [8:0] s;
        s = 9'h012 + 9'h034;
        run_op("R3 add", 8'h12, 8'h34, 4'd1, 3'd0, 2'd2, 2'd1, s[7:0], s[8]);
        run_op("R3 add carryout", 8'hFF, 8'h01, 4'd1, 3'd0, 2'd2, 2'd1, 8'h00, 1'b1);
        run_op("R3 adc flag", 8'h10, 8'h20, 4'd1, 3'd0, 2'd1, 2'd1, 8'h31, 1'b0);
        run_op("R3 cin a7", 8'h80, 8'h01, 4'd1, 3'd0, 2'd0, 2'd1, 8'h82, 1'b0);
        run_op("R3 cin one", 8'hF0, 8'h0F, 4'd1, 3'd0, 2'd3, 2'd1, 8'h00, 1'b1);
    endtask

    task automatic t_sub();    // R4
        run_op("R4 sub noborrow", 8'h50, 8'h20, 4'd2, 3'd0, 2'd3, 2'd1, 8'h30, 1'b1);
        run_op("R4 sub borrow", 8'h20, 8'h50, 4'd2, 3'd0, 2'd3, 2'd1, 8'hD0, 1'b0);
    endtask

    task automatic t_cmp();    // R5
        run_op("R5 cmp b>a", 8'h20, 8'h50, 4'd3, 3'd0, 2'd3, 2'd1, 8'h30, 1'b1);
        pc_in = 8'h11;
        drive(8'h50, 8'h20, 4'd3, 3'd0, 2'd3, 2'd2);
        chk("R5 bus shows pc", bus_out, 8'h11);
        latch();
        chk("R5 cmp carry", {7'd0, carry_q}, 8'd0);
        chk("R5 cmp neg", {7'd0, neg_q}, 8'd1);
    endtask

    task automatic t_logic();  // R6
        run_op("R6 and", 8'hF3, 8'h3C, 4'd4, 3'd0, 2'd3, 2'd1, 8'h30, 1'b0);
        run_op("R6 or", 8'h81, 8'h3C, 4'd5, 3'd0, 2'd3, 2'd1, 8'hBD, 1'b0);
        run_op("R6 xor", 8'hF0, 8'h3C, 4'd6, 3'd0, 2'd3, 2'd1, 8'hCC, 1'b0);
        run_op("R6 move", 8'h9E, 8'h00, 4'd0, 3'd0, 2'd3, 2'd1, 8'h9E, 1'b0);
        run_op("R6 unused code", 8'hFF, 8'hFF, 4'd9, 3'd0, 2'd3, 2'd1, 8'h00, 1'b0);
    endtask

    task automatic t_const();  // R7
        run_op("R7 ones", 8'h12, 8'h34, 4'd8, 3'd0, 2'd3, 2'd1, 8'hFF, 1'b0);
        run_op("R7 clear", 8'h12, 8'h34, 4'd7, 3'd0, 2'd3, 2'd1, 8'h00, 1'b0);
        run_op("R7 inc", 8'h7F, 8'h00, 4'd1, 3'd0, 2'd3, 2'd1, 8'h80, 1'b0);
        run_op("R7 dec wrap", 8'h00, 8'hFF, 4'd1, 3'd0, 2'd2, 2'd1, 8'hFF, 1'b0);
        run_op("R7 dec", 8'h01, 8'hFF, 4'd1, 3'd0, 2'd2, 2'd1, 8'h00, 1'b1);
        run_op("R7 complement", 8'h5A, 8'hFF, 4'd6, 3'd0, 2'd2, 2'd1, 8'hA5, 1'b0);
    endtask

    task automatic t_shift();  // R8, R9
        run_op("R8 asr", 8'h81, 8'h00, 4'd0, 3'd1, 2'd2, 2'd0, 8'hC0, 1'b1);
        run_op("R8 lsr", 8'h81, 8'h00, 4'd0, 3'd2, 2'd2, 2'd0, 8'h40, 1'b1);
        run_op("R8 pass keeps carry", 8'h33, 8'h00, 4'd0, 3'd0, 2'd2, 2'd0, 8'h33, 1'b1);
        run_op("R8 unused shift code", 8'h44, 8'h00, 4'd0, 3'd6, 2'd2, 2'd0, 8'h44, 1'b1);
        run_op("R9 lsl", 8'h81, 8'h00, 4'd0, 3'd3, 2'd2, 2'd0, 8'h02, 1'b1);
        run_op("R9 rlc carry in", 8'h40, 8'h00, 4'd0, 3'd4, 2'd2, 2'd0, 8'h81, 1'b0);
        run_op("R9 rlc zero in", 8'h40, 8'h00, 4'd0, 3'd4, 2'd2, 2'd0, 8'h80, 1'b0);
    endtask

    task automatic t_hold();   // R10
        run_op("R10 set", 8'hFF, 8'h81, 4'd1, 3'd0, 2'd2, 2'd1, 8'h80, 1'b1);
        for (int i = 0; i < 4; i++) begin
            drive(8'h01 << i, 8'h02, 4'd7, 3'd2, 2'd2, 2'(i));
            @(posedge clk);
            #2;
            chk("R10 hold carry", {7'd0, carry_q}, 8'd1);
            chk("R10 hold neg", {7'd0, neg_q}, 8'd1);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_bus();
        t_add();
        t_sub();
        t_cmp();
        t_logic();
        t_const();
        t_shift();
        t_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule